// File: doc/BRIEF.md
# Multi-polynomial PRBS lane checker

This block checks one receive lane, after the deserializer, for a pseudo-random bit sequence. Each clock that carries a valid 64-bit word, it predicts every bit from bits received earlier on the lane. The prediction uses one of four standard polynomials, picked by a one-hot select. It counts the bits that disagree with the prediction. The checker synchronizes itself: the expected sequence comes from the received stream, so the far end needs no agreed seed or phase.

A synchronous soft reset clears the status and captures the configuration. The reset also starts a settle counter. Errors are counted only after that counter reaches a threshold, which a 2-bit code selects. Software reads three outputs once checking is under way:
- a done flag, which shows that checking is active;
- a sticky error flag;
- a saturating count of mismatched bits.

Top module: `prbs_lane_checker`

## Requirements
- R1: While `srst` is high at a clock edge, the block clears `err_count`, `err_seen` and `done` and restarts the hold-off. At that edge it also captures `poly_sel` and `thr_code`.
- R2: `thr_code` selects the hold-off threshold: 00 gives 127, 01 gives 255, 10 gives 511 and 11 gives 1023. With a valid select, `done` is low after threshold−1 clock edges following the release of `srst`. It is high after the edge numbered by the threshold, and it stays high until the next reset. `rx_valid` has no effect on this timing.
- R3: The `poly_sel` bits select the polynomial:
  - bit 0: x^9+x^5+1
  - bit 1: x^15+x^14+1
  - bit 2: x^23+x^18+1
  - bit 3: x^31+x^28+1
- R4: `rx_data[0]` is the earliest bit in time and `rx_data[63]` the latest. A bit is mismatched when it differs from the XOR of the received bits a and b positions earlier in the stream, where x^a+x^b+1 is the selected polynomial. The earlier bits may lie in earlier words. A clean sequence gives zero errors at any starting phase.
- R5: A word is checked when all of the following hold: `rx_valid` is high, `done` was already high before that edge, and the history is primed. For each checked word, `err_count` rises by the number of mismatched bits in that word.
- R6: `err_count` saturates at its all-ones value instead of wrapping.
- R7: `err_seen` sets on the first checked word that has a mismatch. It stays set until the next soft reset.
- R8: If the captured select is zero or has more than one bit set, `done` stays low and no errors are counted.
- R9: A word with `rx_valid` low is ignored. It does not advance the bit history and it is not counted.
- R10: Changes to `poly_sel` or `thr_code` while `srst` is low have no effect.
- R11: The first valid word after a reset only primes the history and is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| srst | input | 1 | Synchronous soft reset, active high |
| rx_data | input | 64 | Deserialized lane word, bit 0 earliest |
| rx_valid | input | 1 | Word strobe |
| poly_sel | input | 4 | One-hot polynomial select |
| thr_code | input | 2 | Hold-off threshold code |
| done | output | 1 | Checking active |
| err_seen | output | 1 | Sticky mismatch flag |
| err_count | output | CNT_W (16) | Saturating mismatched-bit count |

## Verification
The hardest state to reach is the saturation boundary of the count. A single word adds at most 64, so the count climbs slowly. The bench fills the lane with unrelated random words after the hold-off and tracks the expected sum itself until the count pins at all ones, then drives further words.

Two cases also need the bit history to be right, and both are hard to see from the ports:
- The first word after reset must be used only to prime the history. The stimulus starts a fresh sequence with no valid words during the hold-off, so the first checked word depends on that primed history.
- Gaps in `rx_valid` must not advance the history. The stimulus inserts runs of invalid garbage inside a clean sequence, then checks that the count does not move.

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker #(
  parameter int W     = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [W-1:0]     rx_data,
  input  logic             rx_valid,
  input  logic [3:0]       poly_sel,
  input  logic [1:0]       thr_code,
  output logic             done,
  output logic             err_seen,
  output logic [CNT_W-1:0] err_count
);
  localparam int HW  = 31;
  localparam int SW  = HW + W;
  localparam int PCW = $clog2(W + 1);

  function automatic int tap_a(int p);
    case (p)
      0: return 9;
      1: return 15;
      2: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int tap_b(int p);
    case (p)
      0: return 5;
      1: return 14;
      2: return 18;
      default: return 28;
    endcase
  endfunction

  logic [3:0]    sel_q;
  logic [1:0]    thr_q;
  logic [9:0]    hold;
  logic [HW-1:0] hist;
  logic          primed;

  logic [9:0] thr_lim;
  assign thr_lim = 10'((11'd128 << thr_q) - 11'd1);

  logic active, sel_ok;
  assign active = (hold == thr_lim);
  assign sel_ok = $onehot(sel_q);
  assign done   = active & sel_ok;

  logic [SW-1:0] strm;
  assign strm = {rx_data, hist};

  logic [3:0][W-1:0] exp_w;
  for (genvar p = 0; p < 4; p++) begin : g_poly
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign exp_w[p][i] = strm[HW+i-tap_a(p)] ^ strm[HW+i-tap_b(p)];
    end
  end

  logic [W-1:0] exp_sel;
  always_comb begin
    exp_sel = '0;
    for (int p = 0; p < 4; p++)
      if (sel_q[p]) exp_sel |= exp_w[p];
  end

  logic [PCW-1:0] nmiss;
  always_comb begin
    nmiss = '0;
    for (int i = 0; i < W; i++)
      nmiss += PCW'(rx_data[i] ^ exp_sel[i]);
  end

  logic check;
  assign check = rx_valid & active & sel_ok & primed;

  logic [CNT_W:0] sum;
  assign sum = {1'b0, err_count} + (CNT_W+1)'(nmiss);

  always_ff @(posedge clk) begin
    if (srst) begin
      sel_q     <= poly_sel;
      thr_q     <= thr_code;
      hold      <= '0;
      hist      <= '0;
      primed    <= 1'b0;
      err_seen  <= 1'b0;
      err_count <= '0;
    end else begin
      if (!active) hold <= hold + 10'd1;
      if (rx_valid) begin
        hist   <= rx_data[W-1 -: HW];
        primed <= 1'b1;
      end
      if (check) begin
        err_count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        if (nmiss != '0) err_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prbs_lane_checker_sva.sv
module prbs_lane_checker_sva #(
  parameter int W     = 64,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             srst,
  input logic             done,
  input logic             err_seen,
  input logic [CNT_W-1:0] err_count
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    srst |=> (err_count == '0 && !err_seen && !done));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (srst)
    1'b1 |=> (err_count >= $past(err_count)));

  // R5
  step_bound_chk: assert property (@(posedge clk) disable iff (srst)
    1'b1 |=> (int'(err_count) - int'($past(err_count)) <= W));

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (srst)
    err_seen |=> err_seen);

  // R7
  flag_tracks_count_chk: assert property (@(posedge clk) disable iff (srst)
    1'b1 |=> ((err_count != '0) == err_seen));

  // R2
  done_holds_chk: assert property (@(posedge clk) disable iff (srst)
    done |=> done);

  // R8
  idle_no_count_chk: assert property (@(posedge clk) disable iff (srst)
    !done |=> $stable(err_count));
endmodule

bind prbs_lane_checker prbs_lane_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .srst(srst), .done(done), .err_seen(err_seen), .err_count(err_count)
);

// File: tb/prbs_lane_checker_test.sv
module prbs_lane_checker_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic [63:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic [3:0] poly_sel = 4'b0001;
  logic [1:0] thr_code = 2'b00;
  logic done, err_seen;
  logic [CNT_W-1:0] err_count;

  prbs_lane_checker #(.W(64), .CNT_W(CNT_W)) uut (
    .clk(clk), .srst(srst), .rx_data(rx_data), .rx_valid(rx_valid),
    .poly_sel(poly_sel), .thr_code(thr_code),
    .done(done), .err_seen(err_seen), .err_count(err_count)
  );

  always #10 clk = ~clk;

  int vectors = 0, fails = 0;
  bit finished = 0;

  int edges, cnt_m;
  bit primed_m, flag_m;
  logic [3:0] msel;
  logic [1:0] mthr;
  logic [30:0] mr;
  logic [30:0] gs;
  int ga = 9, gb = 5;

  localparam int CMAX = (1 << CNT_W) - 1;

  function automatic int thr_of(logic [1:0] c);
    return (128 << c) - 1;
  endfunction

  function automatic void taps(int idx, output int a, output int b);
    case (idx)
      0: begin a = 9;  b = 5;  end
      1: begin a = 15; b = 14; end
      2: begin a = 23; b = 18; end
      default: begin a = 31; b = 28; end
    endcase
  endfunction

  function automatic int idx_of(logic [3:0] s);
    for (int i = 0; i < 4; i++) if (s[i]) return i;
    return 0;
  endfunction

  function automatic bit msel_ok();
    return $countones(msel) == 1;
  endfunction

  task automatic set_gen(int idx);
    taps(idx, ga, gb);
    gs = 31'($urandom) | 31'd1;
  endtask

  function automatic logic [63:0] gen_word();
    logic [63:0] w;
    for (int i = 0; i < 64; i++) begin
      w[i] = gs[ga-1] ^ gs[gb-1];
      gs = {gs[29:0], w[i]};
    end
    return w;
  endfunction

  task automatic tick(logic [63:0] d, logic v);
    int a, b, mism;
    rx_data = d;
    rx_valid = v;
    @(posedge clk);
    edges++;
    if (v) begin
      taps(idx_of(msel), a, b);
      mism = 0;
      for (int i = 0; i < 64; i++) begin
        if (d[i] != (mr[a-1] ^ mr[b-1])) mism++;
        mr = {mr[29:0], d[i]};
      end
      if ((edges - 1 >= thr_of(mthr)) && msel_ok() && primed_m) begin
        cnt_m = (cnt_m + mism > CMAX) ? CMAX : cnt_m + mism;
        if (mism != 0) flag_m = 1;
      end
      primed_m = 1;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(logic [3:0] s, logic [1:0] t);
    srst = 1'b1;
    poly_sel = s;
    thr_code = t;
    rx_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    srst = 1'b0;
    edges = 0; cnt_m = 0; primed_m = 0; flag_m = 0;
    msel = s; mthr = t; mr = '0;
  endtask

  task automatic check_all(string tag);
    bit d_exp;
    d_exp = (edges >= thr_of(mthr)) && msel_ok();
    vectors++;
    if (done !== d_exp || err_seen !== flag_m || err_count !== CNT_W'(cnt_m)) begin
      fails++;
      $display("FAIL %s: done=%0b err_seen=%0b count=%0d expected done=%0b err_seen=%0b count=%0d",
               tag, done, err_seen, err_count, d_exp, flag_m, cnt_m);
    end
  endtask

  task automatic clean(int n);
    for (int i = 0; i < n; i++) tick(gen_word(), 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(4'b0001, 2'b00);
    check_all("R1 reset state");

    // R2 hold-off sweep over all codes
    for (int c = 0; c < 4; c++) begin
      do_reset(4'b0001, 2'(c));
      set_gen(0);
      clean(thr_of(2'(c)) - 1);
      check_all("R2 before threshold");
      clean(1);
      check_all("R2 at threshold");
    end

    // R3 R4 R5 each polynomial, clean then injected errors; R9 gaps
    for (int p = 0; p < 4; p++) begin
      logic [63:0] w;
      do_reset(4'(1 << p), 2'b00);
      set_gen(p);
      clean(127 + 40);
      check_all("R4 clean stream R3 select");
      for (int k = 0; k < 64; k += 9) begin
        w = gen_word();
        w[k] = ~w[k];
        tick(w, 1'b1);
        check_all("R5 injected error R3");
      end
      for (int g = 0; g < 5; g++) tick(64'($urandom) << 32 | 64'($urandom), 1'b0);
      check_all("R9 invalid words ignored");
      clean(20);
      check_all("R9 history kept across gaps");
    end

    // R11 first valid word only primes history
    do_reset(4'b0010, 2'b00);
    set_gen(1);
    for (int i = 0; i < 130; i++) tick('0, 1'b0);
    clean(1);
    check_all("R11 priming word not counted");
    clean(10);
    check_all("R11 clean after priming");

    // R5 errors during hold-off not counted
    do_reset(4'b0100, 2'b00);
    set_gen(2);
    for (int i = 0; i < 127; i++) tick({$urandom, $urandom}, 1'b1);
    check_all("R5 hold-off words not counted");
    clean(10);
    check_all("R5 boundary after hold-off");

    // R7 sticky flag
    do_reset(4'b0010, 2'b00);
    set_gen(1);
    clean(130);
    begin
      logic [63:0] w;
      w = gen_word();
      w[40] = ~w[40];
      tick(w, 1'b1);
    end
    clean(20);
    check_all("R7 flag sticky");
    if (!err_seen) begin
      fails++;
      $display("FAIL R7: err_seen=%0b expected 1", err_seen);
    end
    vectors++;
    do_reset(4'b0010, 2'b00);
    @(negedge clk);
    check_all("R1 reset clears flag");

    // R6 saturation
    do_reset(4'b0001, 2'b00);
    set_gen(0);
    clean(127);
    while (cnt_m < CMAX) tick({$urandom, $urandom}, 1'b1);
    for (int i = 0; i < 5; i++) tick({$urandom, $urandom}, 1'b1);
    check_all("R6 saturated count");

    // R8 invalid selects
    foreach (msel[i]) ;
    begin
      logic [3:0] bad [4] = '{4'b0000, 4'b0011, 4'b0101, 4'b1111};
      for (int s = 0; s < 4; s++) begin
        do_reset(bad[s], 2'b00);
        for (int i = 0; i < 200; i++) tick({$urandom, $urandom}, 1'b1);
        check_all("R8 invalid select");
      end
    end

    // R10 config change outside reset ignored
    do_reset(4'b0001, 2'b00);
    set_gen(0);
    poly_sel = 4'b0100;
    thr_code = 2'b11;
    clean(127);
    check_all("R10 threshold change ignored");
    clean(20);
    check_all("R10 select change ignored");
    begin
      logic [63:0] w;
      w = gen_word();
      w[3] = ~w[3];
      tick(w, 1'b1);
    end
    check_all("R10 counting with captured select");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule